// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures the frequency of one of several clock inputs by counting its rising edges during a window that lasts a programmed number of periods of a reference clock. Software picks the measured input and the window length, enables the reference, and starts a run by writing the control register. When the run ends, the value register holds the edge count. The measured frequency is value divided by window length, times the reference frequency.

Three clock domains take part. Register access lives in the bus domain. The window timer lives in the reference domain. The edge counter is clocked by the selected measured clock. Start requests, the window gate, the end-of-run event and the reference acknowledge all cross between domains through two-stage synchronizers. Two interrupt causes, run complete and reference ready, are held in sticky status bits. Each cause has a mask bit with its own set and clear addresses. A single interrupt line carries the masked OR of the status bits.

Top module: `freq_meter`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: The mode register (address 0) holds the reference enable in bit 31, the window length in bits [8 +: WIN_W] and the input select in bits [SEL_W-1:0]. It reads back exactly what was written to those fields. All other bits read as zero.
- R3: Writing 1 to bit 0 of the control register (address 1) while idle, with a non-zero window length, starts a run. Bit 0 of the status register (address 2) reads 1 on the next cycle. It returns to 0 when the run ends, and bit 0 of the interrupt status register (address 7) is then set.
- R4: After a run, the value register (address 3) is within one count of window length × measured frequency / reference frequency, for every selectable input.
- R5: A start write while bit 0 of the status register is 1 has no effect. No extra run occurs and the value of the current run is kept.
- R6: A start with a window length of zero begins no run. On the next cycle, interrupt status bit 0 is set, the busy bit stays 0, and the value register reads 0.
- R7: When the edge count would pass all ones (CNT_W bits), the value holds at all ones.
- R8: A write to address 4 sets the interrupt mask bits where the data has ones. A write to address 5 clears them where the data has ones. Zero data bits change nothing. The mask reads back at address 6, with bit 0 = run complete and bit 1 = reference ready.
- R9: An interrupt status bit stays set until a write to address 8 has a one in its position. Zero bits in that write leave it set.
- R10: `irq` is high exactly when some interrupt status bit and its mask bit are both set.
- R11: Changing the reference enable bit sets status bit 1 (reference busy) on the next cycle. The bit clears once the change has been acknowledged from the reference domain. When the reference becomes enabled, interrupt status bit 1 is set.
- R12: When a run completes in the same cycle as a write that clears interrupt status bit 0, the bit ends up set.
- R13: There is no timeout. While the reference is disabled, a started run keeps status bit 0 at 1 indefinitely. It completes once the reference is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| refClk | input | 1 | Reference clock that times the window |
| msrClks | input | SEL_N | Candidate clocks to be measured |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Write strobe, one bus cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Masked OR of the interrupt status bits |

## Verification
The block can see two things in one bus cycle: the synchronized end-of-run event setting interrupt status bit 0, and a software write that clears that same bit. The bench provokes this by enabling the run-complete mask, starting a short run, and then writing a clear of bit 0 on every bus cycle without a gap until `irq` rises. This guarantees that the completion lands on a cycle that also carries a clear. If set wins, `irq` rises and status bit 0 reads 1. If clear wins, `irq` never rises and the loop's limit reports a failure.

// File: rtl/fm_pkg.sv
package fm_pkg;

  localparam int ADDR_W   = 4;
  localparam int IRQ_N    = 2;
  localparam int IRQ_DONE = 0;
  localparam int IRQ_RDY  = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MODE  = 4'd0,
    ADR_CTRL  = 4'd1,
    ADR_STAT  = 4'd2,
    ADR_VALUE = 4'd3,
    ADR_IMSET = 4'd4,
    ADR_IMCLR = 4'd5,
    ADR_IMASK = 4'd6,
    ADR_ISTAT = 4'd7,
    ADR_ICLR  = 4'd8
  } regAddrE;

  // control -> datapath strobes (bus domain levels/toggles)
  typedef struct packed {
    logic startTgl;
    logic refEn;
  } ctlToDpS;

  // datapath -> control (foreign-domain levels/toggles)
  typedef struct packed {
    logic doneTgl;
    logic refAck;
  } dpToCtlS;

endpackage

// File: rtl/fm_sync2.sv
module fm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int WIN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq,
  output ctlToDpS           ctl,
  input  dpToCtlS           dpStat,
  input  logic [CNT_W-1:0]  count,
  output logic [WIN_W-1:0]  runLen,
  output logic [SEL_W-1:0]  runSel,
  output logic              busy,
  output logic              refBusy,
  output logic              modeRefEn,
  output logic [IRQ_N-1:0]  istat,
  output logic [IRQ_N-1:0]  imask,
  output logic [WIN_W-1:0]  modeLen
);

  localparam int LEN_LSB = 8;
  localparam int CNT_PAD = 32 - CNT_W;
  localparam int IRQ_PAD = 32 - IRQ_N;

  logic [SEL_W-1:0] modeSel;
  logic             startTglQ;
  logic             zeroQ;
  logic             doneSyn, doneSynQ;
  logic             ackSyn, ackSynQ;
  logic             wrMode, wrCtrl, wrImSet, wrImClr, wrIClr;
  logic             startReq, runReq, zeroReq;
  logic             doneEv, rdyEv;
  logic [IRQ_N-1:0] setBits, clrBits, mSet, mClr;
  logic [31:0]      modeWord;
  logic             unusedBits;

  assign unusedBits = ^regWrData;

  // foreign-domain toggles and levels into the bus domain
  fm_sync2 #(.W(2)) uBusSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({dpStat.doneTgl, dpStat.refAck}),
    .q   ({doneSyn, ackSyn})
  );

  assign wrMode  = regWr && (regAddr == ADR_MODE);
  assign wrCtrl  = regWr && (regAddr == ADR_CTRL);
  assign wrImSet = regWr && (regAddr == ADR_IMSET);
  assign wrImClr = regWr && (regAddr == ADR_IMCLR);
  assign wrIClr  = regWr && (regAddr == ADR_ICLR);

  assign startReq = wrCtrl && regWrData[0] && !busy;
  assign runReq   = startReq && (modeLen != '0);
  assign zeroReq  = startReq && (modeLen == '0);

  assign doneEv  = doneSyn ^ doneSynQ;
  assign rdyEv   = ackSyn && !ackSynQ;
  assign refBusy = modeRefEn != ackSyn;

  always_comb begin
    setBits           = '0;
    setBits[IRQ_DONE] = doneEv | zeroReq;
    setBits[IRQ_RDY]  = rdyEv;
    clrBits = wrIClr  ? regWrData[IRQ_N-1:0] : '0;
    mSet    = wrImSet ? regWrData[IRQ_N-1:0] : '0;
    mClr    = wrImClr ? regWrData[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRefEn <= 1'b0;
      modeLen   <= '0;
      modeSel   <= '0;
      runLen    <= '0;
      runSel    <= '0;
      busy      <= 1'b0;
      startTglQ <= 1'b0;
      zeroQ     <= 1'b0;
      doneSynQ  <= 1'b0;
      ackSynQ   <= 1'b0;
      istat     <= '0;
      imask     <= '0;
    end else begin
      doneSynQ <= doneSyn;
      ackSynQ  <= ackSyn;
      if (wrMode) begin
        modeRefEn <= regWrData[31];
        modeLen   <= regWrData[LEN_LSB +: WIN_W];
        modeSel   <= regWrData[SEL_W-1:0];
      end
      if (runReq) begin
        busy      <= 1'b1;
        startTglQ <= ~startTglQ;
        runLen    <= modeLen;
        runSel    <= modeSel;
        zeroQ     <= 1'b0;
      end else if (doneEv) begin
        busy <= 1'b0;
      end
      if (zeroReq) zeroQ <= 1'b1;
      // a new event wins over a clear in the same cycle
      istat <= (istat & ~clrBits) | setBits;
      imask <= (imask | mSet) & ~mClr;
    end
  end

  assign irq          = |(istat & imask);
  assign ctl.startTgl = startTglQ;
  assign ctl.refEn    = modeRefEn;

  always_comb begin
    modeWord                     = '0;
    modeWord[31]                 = modeRefEn;
    modeWord[LEN_LSB +: WIN_W]   = modeLen;
    modeWord[SEL_W-1:0]          = modeSel;
    case (regAddr)
      ADR_MODE:  regRdData = modeWord;
      ADR_STAT:  regRdData = {30'd0, refBusy, busy};
      ADR_VALUE: regRdData = zeroQ ? 32'd0 : {{CNT_PAD{1'b0}}, count};
      ADR_IMASK: regRdData = {{IRQ_PAD{1'b0}}, imask};
      ADR_ISTAT: regRdData = {{IRQ_PAD{1'b0}}, istat};
      default:   regRdData = 32'd0;
    endcase
  end

endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int SEL_N = 4,
  parameter int SEL_W = 2,
  parameter int WIN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic             refClk,
  input  logic [SEL_N-1:0] msrClks,
  input  logic             rstN,
  input  ctlToDpS          ctl,
  input  logic [WIN_W-1:0] runLen,
  input  logic [SEL_W-1:0] runSel,
  output dpToCtlS          dpStat,
  output logic [CNT_W-1:0] count
);

  localparam int SLOTS = 2 ** SEL_W;

  // ---------------- reference domain: window timer ----------------
  logic             refOn, startSyn, startSynQ, startEdge, gate;
  logic [WIN_W-1:0] winCnt;

  fm_sync2 #(.W(2)) uRefSync (
    .clk (refClk),
    .rstN(rstN),
    .d   ({ctl.refEn, ctl.startTgl}),
    .q   ({refOn, startSyn})
  );

  assign startEdge = startSyn ^ startSynQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      startSynQ <= 1'b0;
      gate      <= 1'b0;
      winCnt    <= '0;
    end else begin
      startSynQ <= startSyn;
      if (startEdge) begin
        winCnt <= runLen;
        gate   <= (runLen != '0);
      end else if (gate && refOn) begin
        winCnt <= winCnt - WIN_W'(1);
        if (winCnt == WIN_W'(1)) gate <= 1'b0;
      end
    end
  end

  // ---------------- measured clock selection ----------------
  logic [SLOTS-1:0] clkPad;
  logic             msrClk;

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    if (i < SEL_N) begin : gUsed
      assign clkPad[i] = msrClks[i];
    end else begin : gIdle
      assign clkPad[i] = 1'b0;
    end
  end

  assign msrClk = clkPad[runSel];

  // ---------------- measured domain: edge counter ----------------
  logic gateSyn, gateSynQ, doneTglQ;

  fm_sync2 #(.W(1)) uGateSync (
    .clk (msrClk),
    .rstN(rstN),
    .d   (gate),
    .q   (gateSyn)
  );

  always_ff @(posedge msrClk or negedge rstN) begin
    if (!rstN) begin
      gateSynQ <= 1'b0;
      count    <= '0;
      doneTglQ <= 1'b0;
    end else begin
      gateSynQ <= gateSyn;
      if (gateSyn && !gateSynQ)      count <= CNT_W'(1);
      else if (gateSyn && count != '1) count <= count + CNT_W'(1);
      if (!gateSyn && gateSynQ)      doneTglQ <= ~doneTglQ;
    end
  end

  assign dpStat.doneTgl = doneTglQ;
  assign dpStat.refAck  = refOn;

endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int SEL_N = 4,
  parameter int SEL_W = 2,
  parameter int WIN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClk,
  input  logic [SEL_N-1:0]  msrClks,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq
);

  ctlToDpS          ctlW;
  dpToCtlS          dpStatW;
  logic [CNT_W-1:0] countW;
  logic [WIN_W-1:0] runLenW, modeLenW;
  logic [SEL_W-1:0] runSelW;
  logic             busyW, refBusyW, modeRefEnW;
  logic [IRQ_N-1:0] istatW, imaskW;

  fm_ctrl #(.SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .irq      (irq),
    .ctl      (ctlW),
    .dpStat   (dpStatW),
    .count    (countW),
    .runLen   (runLenW),
    .runSel   (runSelW),
    .busy     (busyW),
    .refBusy  (refBusyW),
    .modeRefEn(modeRefEnW),
    .istat    (istatW),
    .imask    (imaskW),
    .modeLen  (modeLenW)
  );

  fm_datapath #(.SEL_N(SEL_N), .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) uDp (
    .refClk (refClk),
    .msrClks(msrClks),
    .rstN   (rstN),
    .ctl    (ctlW),
    .runLen (runLenW),
    .runSel (runSelW),
    .dpStat (dpStatW),
    .count  (countW)
  );

endmodule

// File: rtl/fm_chk.sv
module fm_chk
  import fm_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [31:0]       regWrData,
  input logic              irq,
  input logic              busy,
  input logic              refBusy,
  input logic              modeRefEn,
  input logic              startTgl,
  input logic [IRQ_N-1:0]  istat,
  input logic [IRQ_N-1:0]  imask,
  input logic [WIN_W-1:0]  modeLen
);

  logic wrCtrlGo, wrMaskAny, wrClrDone, wrModeFlip;
  logic unusedBits;

  assign unusedBits = ^regWrData;
  assign wrCtrlGo   = regWr && (regAddr == ADR_CTRL) && regWrData[0];
  assign wrMaskAny  = regWr && ((regAddr == ADR_IMSET) || (regAddr == ADR_IMCLR));
  assign wrClrDone  = regWr && (regAddr == ADR_ICLR) && regWrData[IRQ_DONE];
  assign wrModeFlip = regWr && (regAddr == ADR_MODE) && (regWrData[31] != modeRefEn);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrCtrlGo));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrCtrlGo) |=> $stable(startTgl));

  // R6
  zero_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrlGo && !busy && modeLen == '0) |=> (istat[IRQ_DONE] && !busy));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrMaskAny |=> $stable(imask));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (istat[IRQ_DONE] && !wrClrDone) |=> istat[IRQ_DONE]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (istat == '0) |-> !irq);

  // R11
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refBusy && wrModeFlip) |=> refBusy);

endmodule

bind freq_meter fm_chk #(.WIN_W(WIN_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .regWrData(regWrData),
  .irq      (irq),
  .busy     (busyW),
  .refBusy  (refBusyW),
  .modeRefEn(modeRefEnW),
  .startTgl (ctlW.startTgl),
  .istat    (istatW),
  .imask    (imaskW),
  .modeLen  (modeLenW)
);

// File: tb/sim_freq_meter.sv
`timescale 1ns/1ps
module sim_freq_meter;
  import fm_pkg::*;

  localparam int SEL_N  = 4;
  localparam int SEL_W  = 2;
  localparam int WIN_W  = 8;
  localparam int CNT_W  = 8;
  localparam int REF_NS = 100;
  localparam int MSR_NS [0:3] = '{27, 50, 13, 8};
  localparam int LENS [0:4]   = '{1, 2, 5, 11, 19};

  logic        clk = 1'b0, refClk = 1'b0;
  logic        c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWr;
  logic [31:0] regWrData, regRdData;
  logic        irq;
  logic [SEL_N-1:0] msrClks;

  int errs = 0;
  int checks = 0;

  always #10   clk    = ~clk;
  always #50   refClk = ~refClk;
  always #13.5 c0 = ~c0;
  always #25   c1 = ~c1;
  always #6.5  c2 = ~c2;
  always #4    c3 = ~c3;
  assign msrClks = {c3, c2, c1, c0};

  freq_meter #(.SEL_N(SEL_N), .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .refClk(refClk), .msrClks(msrClks),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(posedge clk);
    #2 regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkFreq(input string tag, input int len, input int p, input logic [31:0] v);
    int diff;
    checks++;
    diff = int'(v) * p - len * REF_NS;
    if (diff < 0) diff = -diff;
    if (diff > p) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (+-1)", tag, v, (len * REF_NS) / p);
    end
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] s;
    int n = 0;
    rd(ADR_STAT, s);
    while (s[0] && n < 4000) begin
      rd(ADR_STAT, s);
      n++;
    end
    chk(tag, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic waitRefSettled(input string tag);
    logic [31:0] s;
    int n = 0;
    rd(ADR_STAT, s);
    while (s[1] && n < 400) begin
      rd(ADR_STAT, s);
      n++;
    end
    chk(tag, {31'd0, s[1]}, 32'd0);
  endtask

  function automatic logic [31:0] modeW(input logic en, input int len, input int sel);
    return {en, 15'd0, 8'(len), 6'd0, 2'(sel)};
  endfunction

  initial begin
    #3000000;
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(ADR_MODE, v);  chk("R1 mode", v, 0);
    rd(ADR_STAT, v);  chk("R1 status", v, 0);
    rd(ADR_VALUE, v); chk("R1 value", v, 0);
    rd(ADR_IMASK, v); chk("R1 mask", v, 0);
    rd(ADR_ISTAT, v); chk("R1 istat", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R8 mask set/clear
    wr(ADR_IMSET, 32'h1); rd(ADR_IMASK, v); chk("R8 set bit0", v, 32'h1);
    wr(ADR_IMSET, 32'h0); rd(ADR_IMASK, v); chk("R8 set zeros", v, 32'h1);
    wr(ADR_IMCLR, 32'h0); rd(ADR_IMASK, v); chk("R8 clr zeros", v, 32'h1);
    wr(ADR_IMSET, 32'h2); rd(ADR_IMASK, v); chk("R8 set bit1", v, 32'h3);
    wr(ADR_IMCLR, 32'h1); rd(ADR_IMASK, v); chk("R8 clr bit0", v, 32'h2);

    // R11 reference enable handshake, R10 irq
    wr(ADR_MODE, modeW(1'b1, 0, 0));
    rd(ADR_STAT, v); chk("R11 ref busy after enable", v, 32'h2);
    waitRefSettled("R11 ref busy clears");
    rd(ADR_ISTAT, v); chk("R11 ready status", v, 32'h2);
    chk("R10 irq masked ready", {31'd0, irq}, 1);
    wr(ADR_ICLR, 32'h0); rd(ADR_ISTAT, v); chk("R9 clear zeros keeps", v, 32'h2);
    wr(ADR_ICLR, 32'h2); rd(ADR_ISTAT, v); chk("R9 clear ready", v, 0);
    chk("R10 irq low after clear", {31'd0, irq}, 0);

    // R2 mode readback
    wr(ADR_MODE, 32'hFFFF_FFFF);
    rd(ADR_MODE, v); chk("R2 mode fields only", v, modeW(1'b1, 255, 3));
    wr(ADR_MODE, modeW(1'b1, 8'hA5, 2));
    rd(ADR_MODE, v); chk("R2 mode readback", v, modeW(1'b1, 8'hA5, 2));

    // R6 zero window
    wr(ADR_MODE, modeW(1'b1, 0, 0));
    wr(ADR_CTRL, 32'h1);
    rd(ADR_ISTAT, v); chk("R6 done at once", v, 32'h1);
    rd(ADR_STAT, v);  chk("R6 not busy", v, 0);
    rd(ADR_VALUE, v); chk("R6 value zero", v, 0);
    chk("R10 irq off, done unmasked", {31'd0, irq}, 0);
    wr(ADR_ICLR, 32'h2); rd(ADR_ISTAT, v); chk("R9 other bit clear keeps done", v, 32'h1);
    wr(ADR_ICLR, 32'h1); rd(ADR_ISTAT, v); chk("R9 done cleared", v, 0);

    // R3 / R4 sweep over inputs and window lengths
    for (int s = 0; s < SEL_N; s++) begin
      for (int k = 0; k < 5; k++) begin
        wr(ADR_MODE, modeW(1'b1, LENS[k], s));
        wr(ADR_CTRL, 32'h1);
        rd(ADR_STAT, v); chk("R3 busy after start", v, 32'h1);
        waitIdle("R3 busy clears");
        rd(ADR_ISTAT, v); chk("R3 done flagged", v, 32'h1);
        rd(ADR_VALUE, v); chkFreq("R4 count", LENS[k], MSR_NS[s], v);
        wr(ADR_ICLR, 32'h1);
      end
    end

    // R7 saturation
    wr(ADR_MODE, modeW(1'b1, 200, 3));
    wr(ADR_CTRL, 32'h1);
    waitIdle("R7 run ends");
    rd(ADR_VALUE, v); chk("R7 saturated", v, 32'hFF);
    wr(ADR_ICLR, 32'h1);

    // R5 start while busy is ignored
    wr(ADR_MODE, modeW(1'b1, 19, 1));
    wr(ADR_CTRL, 32'h1);
    wr(ADR_CTRL, 32'h1);
    waitIdle("R5 run ends");
    rd(ADR_VALUE, v); chkFreq("R5 first run value", 19, MSR_NS[1], v);
    wr(ADR_ICLR, 32'h1);
    repeat (200) @(negedge clk);
    rd(ADR_STAT, v);  chk("R5 no second run", v, 0);
    rd(ADR_ISTAT, v); chk("R5 no second done", v, 0);

    // R12 completion coinciding with a clear write
    wr(ADR_IMSET, 32'h1);
    wr(ADR_MODE, modeW(1'b1, 3, 0));
    wr(ADR_CTRL, 32'h1);
    n = 0;
    do begin
      wr(ADR_ICLR, 32'h1);
      n++;
    end while (!irq && n < 4000);
    chk("R12 irq after coincident set/clear", {31'd0, irq}, 1);
    rd(ADR_ISTAT, v); chk("R12 done kept", v, 32'h1);
    rd(ADR_STAT, v);  chk("R12 idle", v, 0);
    wr(ADR_ICLR, 32'h3);

    // R13 no timeout while reference is off
    wr(ADR_MODE, modeW(1'b0, 5, 0));
    waitRefSettled("R13 ref off settled");
    wr(ADR_CTRL, 32'h1);
    repeat (300) @(negedge clk);
    rd(ADR_STAT, v);  chk("R13 still busy", v, 32'h1);
    rd(ADR_ISTAT, v); chk("R13 no done", v, 0);
    wr(ADR_MODE, modeW(1'b1, 5, 0));
    waitIdle("R13 completes after re-enable");
    rd(ADR_ISTAT, v); chk("R13 done and ready", v, 32'h3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule